// File: doc/BRIEF.md
# SDRAM Clock Gating and Power-Down Controller

This block decides, cycle by cycle, which SDRAM clock outputs run and which clock-enable outputs are driven high. Software sets one run bit per clock output and one enable bit per partition pair. A pair reached through a stopped clock and a low clock-enable cannot be used. The block reports that pair as dead and never grants a transfer to it.

With automatic power-down switched on, the block stops every clock and drops every clock-enable after any cycle that carries no usable request. When a request then arrives, the block withholds ready for that single cycle while the clocks restart, and grants the transfer in the next cycle. A request that follows directly on the previous one keeps the clocks running and pays nothing.

The block also keeps a 32-bit low-power mode-register word that holds one 15-bit value and one enable bit for each partition pair. When a low-power entry pulse arrives, each pair whose enable bit is set receives its value together with a one-cycle load strobe.

Top module: `sdram_clkpd_ctl`

## Requirements
- R1: After reset, no internal state is powered down, so `clk_gate` equals `run_bits` and `cke_out` equals `cke_bits`. `lp_ld` and `lp_val` are zero, and the stored mode word is zero, so a low-power entry straight after reset produces no strobe.
- R2: While automatic power-down is off, `clk_gate[i]` follows `run_bits[i]` and `cke_out[p]` follows `cke_bits[p]` in the same cycle.
- R3: Pair p is reachable through clock output p+1 (output 0 serves no pair). `pair_live[p]` is `run_bits[p+1] | cke_bits[p]`. `req_rdy` is high only when `req` is high, the addressed pair is live, and the clocks are not stopped.
- R4: With `apd_en` high, a cycle that has no request to a live pair makes every `clk_gate` and `cke_out` bit zero in the following cycle.
- R5: A request to a live pair while the clocks are stopped sees `req_rdy` low in that cycle. The clocks restart, and `req_rdy` is high, in the next cycle if the request is held.
- R6: Requests to a live pair presented on consecutive cycles keep the clocks running, and `req_rdy` stays high on every one of them.
- R7: Clearing `apd_en` restores `clk_gate` and `cke_out` to the software bits in the next cycle.
- R8: `lpm_we` loads `lpm_wdata` into the mode word. Bit 15 enables pair 0, whose value sits in bits 14:0. Bit 31 enables pair 1, whose value sits in bits 30:16.
- R9: One cycle after `lp_enter`, `lp_ld[p]` pulses for each pair whose enable bit is set, and `lp_val[15p+14:15p]` carries that pair's value. A pair whose enable bit is clear gets no strobe and keeps its previous `lp_val`.
- R10: When `lpm_we` and `lp_enter` arrive in the same cycle, the strobe and value come from the word held before the write.
- R11: A request to a dead pair neither wakes stopped clocks nor keeps running clocks awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_bits | input | 3 | Software run bit per clock output |
| cke_bits | input | 2 | Software clock-enable bit per partition pair |
| apd_en | input | 1 | Automatic power-down enable |
| req | input | 1 | Transfer request, held until granted |
| req_pair | input | 1 | Partition pair addressed by the request |
| req_rdy | output | 1 | Transfer granted in this cycle |
| pair_live | output | 2 | Pair reachable through its clock or clock-enable |
| clk_gate | output | 3 | Gate enable per clock output |
| cke_out | output | 2 | Clock-enable level per pair |
| lpm_we | input | 1 | Write strobe for the low-power mode word |
| lpm_wdata | input | 32 | Low-power mode word to store |
| lp_enter | input | 1 | Low-power entry pulse |
| lp_ld | output | 2 | One-cycle load strobe per pair |
| lp_val | output | 30 | Mode-register value per pair, pair 0 in the low 15 bits |

## Verification
The bench checks that a request spaced one idle cycle after the previous transfer pays the restart cycle, and that a request arriving directly on the next cycle does not. If the idle decision were taken one cycle late, the gap would go unpunished. If it were taken one cycle early, back-to-back traffic would stall. The bench also drives requests at dead pairs while the clocks are stopped and while they run. A design that treated any raised `req` as activity would wake the clocks for a transfer it can never grant. The bench writes the mode word and raises low-power entry in the same cycle, which catches a design that strobes the new value. It also sets one enable bit at a time, which exposes swapped or shared enables between the pairs.

// File: rtl/sdram_clkpd_ctl.sv
module sdram_clkpd_ctl #(
  parameter int NPAIR  = 2,
  parameter int MRS_W  = 15,
  parameter int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPAIR:0]            run_bits,
  input  logic [NPAIR-1:0]          cke_bits,
  input  logic                      apd_en,
  input  logic                      req,
  input  logic [PAIR_W-1:0]         req_pair,
  output logic                      req_rdy,
  output logic [NPAIR-1:0]          pair_live,
  output logic [NPAIR:0]            clk_gate,
  output logic [NPAIR-1:0]          cke_out,
  input  logic                      lpm_we,
  input  logic [NPAIR*(MRS_W+1)-1:0] lpm_wdata,
  input  logic                      lp_enter,
  output logic [NPAIR-1:0]          lp_ld,
  output logic [NPAIR*MRS_W-1:0]    lp_val
);
  localparam int FLD_W  = MRS_W + 1;
  localparam int WORD_W = NPAIR * FLD_W;

  logic              pd_q;
  logic              tgt_ok;
  logic              wake;
  logic [WORD_W-1:0] word_q;

  assign tgt_ok = (int'(req_pair) < NPAIR) ? pair_live[req_pair] : 1'b0;
  assign wake   = req & tgt_ok;
  assign req_rdy  = wake & ~pd_q;
  assign clk_gate = run_bits & {(NPAIR+1){~pd_q}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= apd_en & ~wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      word_q <= '0;
    else if (lpm_we) word_q <= lpm_wdata;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic             en;
    logic             ld_q;
    logic [MRS_W-1:0] val_q;

    assign en           = word_q[p*FLD_W + MRS_W];
    assign pair_live[p] = run_bits[p+1] | cke_bits[p];
    assign cke_out[p]   = cke_bits[p] & ~pd_q;
    assign lp_ld[p]     = ld_q;
    assign lp_val[p*MRS_W +: MRS_W] = val_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ld_q  <= 1'b0;
        val_q <= '0;
      end else begin
        ld_q <= lp_enter & en;
        if (lp_enter && en) val_q <= word_q[p*FLD_W +: MRS_W];
      end

    p_strobe_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ld[p] |-> $past(lp_enter));
  end

  p_rdy_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_rdy |-> (req && pair_live[req_pair]));

  p_idle_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (apd_en && !req) |=> (clk_gate == '0 && cke_out == '0));

  p_wake_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pair_live[req_pair] && !req_rdy)
      |=> (req_rdy || !req || !pair_live[req_pair]));

  p_apd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!apd_en) |-> (clk_gate == run_bits && cke_out == cke_bits));
endmodule

// File: tb/tb_sdram_clkpd_ctl.sv
module tb_sdram_clkpd_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  run_bits = 0;
  logic [1:0]  cke_bits = 0;
  logic        apd_en = 0;
  logic        req = 0;
  logic        req_pair = 0;
  logic        lpm_we = 0;
  logic [31:0] lpm_wdata = 0;
  logic        lp_enter = 0;
  logic        req_rdy;
  logic [1:0]  pair_live, cke_out, lp_ld;
  logic [2:0]  clk_gate;
  logic [29:0] lp_val;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_clkpd_ctl dut (
    .clk(clk), .rst_n(rst_n), .run_bits(run_bits), .cke_bits(cke_bits),
    .apd_en(apd_en), .req(req), .req_pair(req_pair), .req_rdy(req_rdy),
    .pair_live(pair_live), .clk_gate(clk_gate), .cke_out(cke_out),
    .lpm_we(lpm_we), .lpm_wdata(lpm_wdata), .lp_enter(lp_enter),
    .lp_ld(lp_ld), .lp_val(lp_val));

  // behavioural reference
  bit          m_down;
  bit [31:0]   m_word;
  bit [1:0]    m_ld;
  int          m_v0, m_v1;

  function automatic bit live(int p);
    return run_bits[p+1] || cke_bits[p];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_down = 0; m_word = 0; m_ld = 0; m_v0 = 0; m_v1 = 0;
    end else begin
      m_down = apd_en && !(req && live(req_pair));
      m_ld[0] = lp_enter && m_word[15];
      m_ld[1] = lp_enter && m_word[31];
      if (m_ld[0]) m_v0 = m_word[14:0];
      if (m_ld[1]) m_v1 = m_word[30:16];
      if (lpm_we) m_word = lpm_wdata;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic compare_all();
    #1;
    chk({tag, " pair_live"}, pair_live, {live(1), live(0)});
    chk({tag, " clk_gate"}, clk_gate, m_down ? 0 : run_bits);
    chk({tag, " cke_out"}, cke_out, m_down ? 0 : cke_bits);
    chk({tag, " req_rdy"}, req_rdy, req && live(req_pair) && !m_down);
    chk({tag, " lp_ld"}, lp_ld, m_ld);
    chk({tag, " lp_val"}, lp_val, {m_v1[14:0], m_v0[14:0]});
  endtask

  task automatic step();
    compare_all();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, empty word gives no strobe
    tag = "R1";
    #1;
    chk("R1 clk_gate after reset", clk_gate, 0);
    chk("R1 lp_val after reset", lp_val, 0);
    run_bits = 3'b101; cke_bits = 2'b10; step();
    lp_enter = 1; step(); lp_enter = 0;
    #1 chk("R1 no strobe from reset word", lp_ld, 0);
    step();

    // R2 / R3: software bits with power-down off
    tag = "R2";
    for (int i = 0; i < 32; i++) begin
      run_bits = i[2:0]; cke_bits = i[4:3]; step();
    end
    tag = "R3";
    run_bits = 3'b001; cke_bits = 2'b00; req = 1; req_pair = 0; step();
    #1 chk("R3 dead pair 0 not granted", req_rdy, 0);
    run_bits = 3'b100; req_pair = 1; step();
    #1 chk("R3 pair 1 live by clock 2", req_rdy, 1);
    req_pair = 0; step();
    cke_bits = 2'b01; step();
    req = 0; step();

    // R8 / R9: mode word fields and strobes
    tag = "R8";
    lpm_we = 1; lpm_wdata = 32'h0000_9234; step(); lpm_we = 0;
    tag = "R9";
    lp_enter = 1; step(); lp_enter = 0;
    #1 chk("R9 pair0 strobe only", lp_ld, 2'b01);
    chk("R8 pair0 value", lp_val[14:0], 15'h1234);
    step();
    lpm_we = 1; lpm_wdata = 32'hD555_0777; step(); lpm_we = 0;
    lp_enter = 1; step(); lp_enter = 0;
    #1 chk("R9 pair1 strobe only", lp_ld, 2'b10);
    chk("R8 pair1 value", lp_val[29:15], 15'h5555);
    chk("R9 pair0 value held", lp_val[14:0], 15'h1234);
    step();
    lpm_we = 1; lpm_wdata = 32'hFFFF_FFFF; step();
    lpm_wdata = 32'h0000_0000; lp_enter = 1;
    tag = "R10";
    step(); lpm_we = 0; lp_enter = 0;
    #1 chk("R10 strobe from old word", lp_ld, 2'b11);
    chk("R10 value from old word", lp_val, 30'h3FFF_FFFF);
    step();
    lp_enter = 1; step(); lp_enter = 0;
    #1 chk("R9 cleared enables no strobe", lp_ld, 0);
    step();

    // R4..R7, R11: automatic power-down
    tag = "R4";
    run_bits = 3'b111; cke_bits = 2'b11; apd_en = 1; step();
    #1 chk("R4 idle stops clocks", clk_gate, 0);
    step(); step();
    tag = "R5";
    req = 1; req_pair = 1; step();
    #1 chk("R5 ready after one restart cycle", req_rdy, 1);
    chk("R5 clocks restarted", clk_gate, 3'b111);
    tag = "R6";
    for (int i = 0; i < 6; i++) begin
      req_pair = i[0]; step();
    end
    req = 0; step();
    tag = "R5";
    req = 1; step();
    req = 0; step();
    tag = "R11";
    run_bits = 3'b011; cke_bits = 2'b01; step(); step();
    req = 1; req_pair = 1; step(); step();
    #1 chk("R11 dead request keeps clocks stopped", clk_gate, 0);
    req_pair = 0; step(); step();
    req_pair = 1; step(); step();
    tag = "R7";
    req = 0; step();
    apd_en = 0; step();
    #1 chk("R7 clocks back with power-down off", clk_gate, 3'b011);
    step(); step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule